// File: doc/BRIEF.md
# Index/Data Configuration Port

This block gives a host a small configuration space that it reaches through only two byte-wide I/O locations. The lower location holds a pointer (the index) that selects one configuration register. The upper location is a window onto whichever register the pointer currently selects, so reading or writing it accesses that register. A strap input picks which of two I/O address pairs the port answers on. The block captures the strap while reset is asserted and keeps that choice until the next reset.

A device-select register (at index 07h) decides who can reach a window of per-device registers at indexes 30h through 71h. Those registers respond only while the device-select register holds 1Ah. The registers in the window drive the device's configuration outputs: an enable, a 16-bit I/O base, an IRQ setting byte and an IRQ type byte. Some bits of these registers are fixed and ignore writes. The host side is a simple strobe interface: address, write data, a write strobe and a read strobe. The strobes are sampled on the rising clock edge. Read data is registered.

Top module: `cfg_index_pair`

## Requirements
- R1: With the strap high during reset, the index register is at I/O address 007Eh and the data register is at 007Fh. Reads of any other address return 00h, and writes to any other address change nothing.
- R2: With the strap low during reset, the index register is at 00EEh and the data register is at 00EFh.
- R3: The index register is 8-bit read/write and reads back the last value written to it.
- R4: After reset: index 00h, device-select 00h, enable register 00h, I/O base 0000h, IRQ setting 00h, IRQ type 03h. The read data output is 00h and the device is disabled.
- R5: The device-select register at index 07h is 8-bit read/write and is always reachable.
- R6: Index 20h reads FEh and index 27h reads the revision parameter (default 01h). Both are read-only.
- R7: While the device-select register is not 1Ah, indexes 30h–71h read 00h and ignore writes. Their contents are kept and become visible again once 1Ah is restored.
- R8: Index 60h holds I/O base bits 15–8. Index 61h holds bits 7–0, but bits 3–0 always read 0 and drive 0 on the base output.
- R9: Index 71h (IRQ type) has only bit 1 writable. Bit 0 always reads 1 and the other bits always read 0.
- R10: Unimplemented indexes, including unused indexes inside the 30h–71h window, read 00h and ignore writes.
- R11: A read strobe places its data on the read data output after the same rising edge, and the data holds until the next read strobe. A write changes the configuration outputs after the edge that samples the strobe, and not before.
- R12: The strap is sampled only while reset is asserted. Changing it after reset does not move the port's addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; the strap is captured while it is low |
| strapHi | input | 1 | Address-pair strap (1: 7Eh/7Fh, 0: EEh/EFh) |
| ioAddr | input | 16 | Host I/O address |
| ioWrData | input | 8 | Host write data |
| ioWr | input | 1 | Write strobe, one cycle per access |
| ioRd | input | 1 | Read strobe, one cycle per access |
| ioRdData | output | 8 | Registered read data |
| devEnable | output | 1 | Bit 0 of the enable register |
| ioBase | output | 16 | Configured I/O base address |
| irqCfg | output | 8 | IRQ number and wake enable byte |
| irqType | output | 8 | IRQ type byte |

## Verification
Both read and write results are due one rising edge after the strobe. The bench drives each strobe on a falling edge and samples on the following falling edge, half a period after the edge that registers the result. For the write-latency check, the enable output is also sampled before that edge to confirm it has not yet changed. Strap capture is checked by changing the strap only after reset is released and then confirming the port still answers at the pair chosen during reset.

// File: rtl/cfgpair_pkg.sv
package cfgpair_pkg;
  localparam int DATA_W = 8;
  localparam int BASE_W = 16;
  localparam int BASE_FIXED_BITS = 4;

  localparam logic [DATA_W-1:0] LDN_MATCH = 8'h1A;
  localparam logic [DATA_W-1:0] IDX_LDN   = 8'h07;
  localparam logic [DATA_W-1:0] IDX_DEVID = 8'h20;
  localparam logic [DATA_W-1:0] IDX_REVID = 8'h27;
  localparam logic [DATA_W-1:0] IDX_ACT   = 8'h30;
  localparam logic [DATA_W-1:0] IDX_BASEH = 8'h60;
  localparam logic [DATA_W-1:0] IDX_BASEL = 8'h61;
  localparam logic [DATA_W-1:0] IDX_IRQ   = 8'h70;
  localparam logic [DATA_W-1:0] IDX_IRQT  = 8'h71;
  localparam logic [DATA_W-1:0] WIN_LO    = 8'h30;
  localparam logic [DATA_W-1:0] WIN_HI    = 8'h71;

  typedef struct packed {
    logic              idxWr;
    logic              dataWr;
    logic              idxRd;
    logic              dataRd;
    logic              anyRd;
    logic [DATA_W-1:0] wrData;
  } pairStrobe_t;
endpackage

// File: rtl/cfg_pair_ctrl.sv
module cfg_pair_ctrl
  import cfgpair_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PAIR_HI = 16'h007E,
  parameter logic [ADDR_W-1:0] PAIR_LO = 16'h00EE
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapHi,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0] ioWrData,
  input  logic              ioWr,
  input  logic              ioRd,
  output pairStrobe_t       strb
);
  logic              strapQ;
  logic [ADDR_W-1:0] pairBase;
  logic              hitIdx;
  logic              hitData;

  // strap is followed only while reset is held (R12)
  always_ff @(posedge clk) begin
    if (!rstN) strapQ <= strapHi;
  end

  assign pairBase = strapQ ? PAIR_HI : PAIR_LO;
  assign hitIdx   = (ioAddr == pairBase);
  assign hitData  = (ioAddr == pairBase + ADDR_W'(1));

  always_comb begin
    strb.idxWr  = ioWr & hitIdx;
    strb.dataWr = ioWr & hitData;
    strb.idxRd  = ioRd & hitIdx;
    strb.dataRd = ioRd & hitData;
    strb.anyRd  = ioRd;
    strb.wrData = ioWrData;
  end

  p_strap_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    $stable(strapQ))
    else $error("strap latch moved outside reset");
endmodule

// File: rtl/cfg_pair_regs.sv
module cfg_pair_regs
  import cfgpair_pkg::*;
#(
  parameter logic [DATA_W-1:0] DEV_ID = 8'hFE,
  parameter logic [DATA_W-1:0] REV_ID = 8'h01
) (
  input  logic              clk,
  input  logic              rstN,
  input  pairStrobe_t       strb,
  output logic [DATA_W-1:0] ioRdData,
  output logic              devEnable,
  output logic [BASE_W-1:0] ioBase,
  output logic [DATA_W-1:0] irqCfg,
  output logic [DATA_W-1:0] irqType
);
  localparam int BASE_LO_KEEP = DATA_W - BASE_FIXED_BITS;

  logic [DATA_W-1:0]       idxQ;
  logic [DATA_W-1:0]       ldnQ;
  logic [DATA_W-1:0]       actQ;
  logic [DATA_W-1:0]       baseHiQ;
  logic [BASE_LO_KEEP-1:0] baseLoQ;
  logic [DATA_W-1:0]       irqCfgQ;
  logic                    irqTypeQ;
  logic [DATA_W-1:0]       rdQ;
  logic [DATA_W-1:0]       regRd;
  logic                    inWin;
  logic                    devSel;
  logic                    wrOk;

  assign inWin  = (idxQ >= WIN_LO) && (idxQ <= WIN_HI);
  assign devSel = (ldnQ == LDN_MATCH);
  assign wrOk   = strb.dataWr && (!inWin || devSel);   // R7

  always_comb begin
    unique case (idxQ)
      IDX_LDN:   regRd = ldnQ;
      IDX_DEVID: regRd = DEV_ID;
      IDX_REVID: regRd = REV_ID;
      IDX_ACT:   regRd = actQ;
      IDX_BASEH: regRd = baseHiQ;
      IDX_BASEL: regRd = {baseLoQ, {BASE_FIXED_BITS{1'b0}}};     // R8
      IDX_IRQ:   regRd = irqCfgQ;
      IDX_IRQT:  regRd = {{(DATA_W-2){1'b0}}, irqTypeQ, 1'b1};   // R9
      default:   regRd = '0;                                     // R10
    endcase
    if (inWin && !devSel) regRd = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ <= '0;
    end else if (strb.idxWr) begin
      idxQ <= strb.wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ldnQ     <= '0;
      actQ     <= '0;
      baseHiQ  <= '0;
      baseLoQ  <= '0;
      irqCfgQ  <= '0;
      irqTypeQ <= 1'b1;
    end else if (wrOk) begin
      unique case (idxQ)
        IDX_LDN:   ldnQ     <= strb.wrData;
        IDX_ACT:   actQ     <= strb.wrData;
        IDX_BASEH: baseHiQ  <= strb.wrData;
        IDX_BASEL: baseLoQ  <= strb.wrData[DATA_W-1:BASE_FIXED_BITS];
        IDX_IRQ:   irqCfgQ  <= strb.wrData;
        IDX_IRQT:  irqTypeQ <= strb.wrData[1];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdQ <= '0;
    end else if (strb.anyRd) begin
      if (strb.idxRd)       rdQ <= idxQ;
      else if (strb.dataRd) rdQ <= regRd;
      else                  rdQ <= '0;
    end
  end

  assign ioRdData  = rdQ;
  assign devEnable = actQ[0];
  assign ioBase    = {baseHiQ, baseLoQ, {BASE_FIXED_BITS{1'b0}}};
  assign irqCfg    = irqCfgQ;
  assign irqType   = {{(DATA_W-2){1'b0}}, irqTypeQ, 1'b1};

  p_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dataWr && inWin && !devSel) |=>
      $stable({actQ, baseHiQ, baseLoQ, irqCfgQ, irqTypeQ}))
    else $error("gated write changed a device register");

  p_devid_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dataRd && idxQ == IDX_DEVID) |=> (ioRdData == DEV_ID))
    else $error("device id read wrong");
endmodule

// File: rtl/cfg_index_pair.sv
module cfg_index_pair
  import cfgpair_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PAIR_HI = 16'h007E,
  parameter logic [ADDR_W-1:0] PAIR_LO = 16'h00EE,
  parameter logic [7:0] DEV_ID = 8'hFE,
  parameter logic [7:0] REV_ID = 8'h01
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapHi,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [7:0]        ioWrData,
  input  logic              ioWr,
  input  logic              ioRd,
  output logic [7:0]        ioRdData,
  output logic              devEnable,
  output logic [15:0]       ioBase,
  output logic [7:0]        irqCfg,
  output logic [7:0]        irqType
);
  pairStrobe_t strb;

  cfg_pair_ctrl #(.ADDR_W(ADDR_W), .PAIR_HI(PAIR_HI), .PAIR_LO(PAIR_LO)) u_ctrl (
    .clk(clk), .rstN(rstN), .strapHi(strapHi), .ioAddr(ioAddr),
    .ioWrData(ioWrData), .ioWr(ioWr), .ioRd(ioRd), .strb(strb)
  );

  cfg_pair_regs #(.DEV_ID(DEV_ID), .REV_ID(REV_ID)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .ioRdData(ioRdData),
    .devEnable(devEnable), .ioBase(ioBase), .irqCfg(irqCfg), .irqType(irqType)
  );

  p_cfg_stable_r11: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ioWr) |-> $stable({devEnable, ioBase, irqCfg, irqType}))
    else $error("configuration changed without a write");

  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ioRd) |-> $stable(ioRdData))
    else $error("read data moved without a read");
endmodule

// File: tb/cfg_index_pair_tb.sv
module cfg_index_pair_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        strapHi = 1'b1;
  logic [15:0] ioAddr = '0;
  logic [7:0]  ioWrData = '0;
  logic        ioWr = 1'b0;
  logic        ioRd = 1'b0;
  logic [7:0]  ioRdData;
  logic        devEnable;
  logic [15:0] ioBase;
  logic [7:0]  irqCfg;
  logic [7:0]  irqType;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cfg_index_pair u_dut (
    .clk(clk), .rstN(rstN), .strapHi(strapHi), .ioAddr(ioAddr),
    .ioWrData(ioWrData), .ioWr(ioWr), .ioRd(ioRd), .ioRdData(ioRdData),
    .devEnable(devEnable), .ioBase(ioBase), .irqCfg(irqCfg), .irqType(irqType)
  );

  // {isRead, req, addr, data-or-expected}
  localparam int NV = 47;
  localparam logic [28:0] VEC [NV] = '{
    {1'b1, 4'd3,  16'h007E, 8'h00},  // R3 index reset
    {1'b0, 4'd5,  16'h007E, 8'h07},
    {1'b1, 4'd5,  16'h007F, 8'h00},  // R5 reset value
    {1'b0, 4'd5,  16'h007F, 8'h1A},
    {1'b1, 4'd5,  16'h007F, 8'h1A},  // R5 readback
    {1'b0, 4'd6,  16'h007E, 8'h20},
    {1'b1, 4'd6,  16'h007F, 8'hFE},  // R6 device id
    {1'b0, 4'd6,  16'h007F, 8'h55},
    {1'b1, 4'd6,  16'h007F, 8'hFE},  // R6 read-only
    {1'b0, 4'd6,  16'h007E, 8'h27},
    {1'b1, 4'd6,  16'h007F, 8'h01},  // R6 revision
    {1'b1, 4'd3,  16'h007E, 8'h27},  // R3 index readback
    {1'b0, 4'd9,  16'h007E, 8'h71},
    {1'b1, 4'd4,  16'h007F, 8'h03},  // R4 type reset
    {1'b0, 4'd9,  16'h007F, 8'h00},
    {1'b1, 4'd9,  16'h007F, 8'h01},  // R9 bit0 fixed
    {1'b0, 4'd9,  16'h007F, 8'hFF},
    {1'b1, 4'd9,  16'h007F, 8'h03},  // R9 only bit1
    {1'b0, 4'd8,  16'h007E, 8'h61},
    {1'b0, 4'd8,  16'h007F, 8'hA5},
    {1'b1, 4'd8,  16'h007F, 8'hA0},  // R8 low nibble zero
    {1'b0, 4'd8,  16'h007E, 8'h60},
    {1'b0, 4'd8,  16'h007F, 8'h3C},
    {1'b1, 4'd8,  16'h007F, 8'h3C},  // R8 high byte
    {1'b0, 4'd11, 16'h007E, 8'h30},
    {1'b0, 4'd11, 16'h007F, 8'h01},
    {1'b1, 4'd11, 16'h007F, 8'h01},  // R11 enable reg
    {1'b0, 4'd11, 16'h007E, 8'h70},
    {1'b0, 4'd11, 16'h007F, 8'h4B},
    {1'b1, 4'd11, 16'h007F, 8'h4B},  // R11 irq byte
    {1'b0, 4'd10, 16'h007E, 8'h50},
    {1'b0, 4'd10, 16'h007F, 8'h77},
    {1'b1, 4'd10, 16'h007F, 8'h00},  // R10 hole in window
    {1'b0, 4'd7,  16'h007E, 8'h07},
    {1'b0, 4'd7,  16'h007F, 8'h05},
    {1'b0, 4'd7,  16'h007E, 8'h60},
    {1'b1, 4'd7,  16'h007F, 8'h00},  // R7 gated read
    {1'b0, 4'd7,  16'h007F, 8'h99},
    {1'b0, 4'd7,  16'h007E, 8'h07},
    {1'b0, 4'd7,  16'h007F, 8'h1A},
    {1'b0, 4'd7,  16'h007E, 8'h60},
    {1'b1, 4'd7,  16'h007F, 8'h3C},  // R7 write was dropped
    {1'b1, 4'd1,  16'h00EF, 8'h00},  // R1 other pair idle
    {1'b0, 4'd1,  16'h00EE, 8'h12},
    {1'b1, 4'd1,  16'h007E, 8'h60},  // R1 index untouched
    {1'b0, 4'd10, 16'h007E, 8'hFF},
    {1'b1, 4'd10, 16'h007F, 8'h00}   // R10 unimplemented
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic ioWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioWrData = d; ioWr = 1'b1;
    @(negedge clk);
    ioWr = 1'b0;
  endtask

  task automatic ioRead(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioRd = 1'b1;
    @(negedge clk);
    ioRd = 1'b0;
    d = ioRdData;
  endtask

  task automatic doReset(input logic strap);
    @(negedge clk);
    rstN = 1'b0; strapHi = strap;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    doReset(1'b1);
    // R4 reset state
    chk("R4 rdata", {8'h0, ioRdData}, 16'h0000);
    chk("R4 enable", {15'h0, devEnable}, 16'h0000);
    chk("R4 base", ioBase, 16'h0000);
    chk("R4 irq", {8'h0, irqCfg}, 16'h0000);
    chk("R4 type", {8'h0, irqType}, 16'h0003);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][28]) begin
        ioRead(VEC[i][23:8], rd);
        chk($sformatf("R%0d vec%0d", VEC[i][27:24], i), {8'h0, rd}, {8'h0, VEC[i][7:0]});
      end else begin
        ioWrite(VEC[i][23:8], VEC[i][7:0]);
      end
    end

    // R8 R11 outputs follow the registers
    chk("R8 base out", ioBase, 16'h3CA0);
    chk("R11 enable out", {15'h0, devEnable}, 16'h0001);
    chk("R11 irq out", {8'h0, irqCfg}, 16'h004B);
    chk("R9 type out", {8'h0, irqType}, 16'h0003);

    // R11 write lands after the sampling edge, not before
    ioWrite(16'h007E, 8'h30);
    @(negedge clk);
    ioAddr = 16'h007F; ioWrData = 8'h00; ioWr = 1'b1;
    #5;
    chk("R11 before edge", {15'h0, devEnable}, 16'h0001);
    @(negedge clk);
    ioWr = 1'b0;
    chk("R11 after edge", {15'h0, devEnable}, 16'h0000);

    // R2 and R12: strap low in reset, then raised afterwards
    doReset(1'b0);
    chk("R4 type after reset", {8'h0, irqType}, 16'h0003);
    chk("R4 base after reset", ioBase, 16'h0000);
    @(negedge clk);
    strapHi = 1'b1;
    ioWrite(16'h00EE, 8'h20);
    ioRead(16'h00EF, rd);
    chk("R2 data port", {8'h0, rd}, 16'h00FE);
    ioRead(16'h007F, rd);
    chk("R12 old pair idle", {8'h0, rd}, 16'h0000);
    ioRead(16'h00EE, rd);
    chk("R2 index port", {8'h0, rd}, 16'h0020);
    ioWrite(16'h007E, 8'h07);
    ioRead(16'h00EE, rd);
    chk("R12 write ignored", {8'h0, rd}, 16'h0020);
    ioWrite(16'h00EE, 8'h07);
    ioRead(16'h00EF, rd);
    chk("R4 ldn reset", {8'h0, rd}, 16'h0000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule